// File: doc/BRIEF.md
# Two-Pattern Memory Self-Test Engine

This block is a built-in self-test controller for a word-addressed memory behind a synchronous single-cycle port. When started, it writes a fixed 32-bit pattern into every word of a region set by parameters. It then reads the whole region back and compares each word against the pattern. After that it repeats the write and read steps with the bitwise complement of the pattern. Read data is taken one cycle after the address is issued.

During both read steps, every mismatch is logged. The log keeps two failure counters, chosen by the low nibble of the byte address. It also keeps the highest failing byte address and a 32-bit map of failing address windows. At the end the block packs these logs into one coded status word and raises a pass flag. A one-cycle done pulse marks the end of the run. The results then hold until the next start.

Top module: `bist_top`

## Requirements
- R1: A start pulse seen while idle clears every log and begins a run. A start pulse seen while busy has no effect: the run keeps its course and its timing.
- R2: The write step drives `mem_we` for one cycle per word. It covers the region from `BASE_ADDR` upward in ascending byte addresses, 4 bytes apart, in groups of `BURST_WORDS` consecutive words. The first pass writes 0xAAAAAAAA.
- R3: The read step issues every word address once in ascending order. It compares `mem_rdata` in the cycle after each address, and the last word of the region is compared too.
- R4: The second pass writes and checks 0x55555555. The logs from the first pass are kept and added to.
- R5: A mismatch at a byte address whose bits [3:0] are below 8 increments `fail_lo_cnt`. Any other mismatch increments `fail_hi_cnt`.
- R6: The highest failing byte address is replaced only by a strictly greater failing address. It starts at 0.
- R7: A mismatch sets bit number addr[22:18] of `fail_map`, where addr is the byte address of the failing word.
- R8: `status` has 0x04 in bits [31:24]. Bit 25 is ORed in when `fail_hi_cnt` is nonzero, and bit 24 when `fail_lo_cnt` is nonzero. The highest failing byte address shifted right by 2 is ORed over the word.
- R9: `pass` is 1 exactly when both failure counters are zero.
- R10: `done` is high for one cycle, 4*W+2 clock edges after the edge that accepts start, where W is the number of words in the region. `status`, `pass`, the counters and `fail_map` stay unchanged until the next accepted start.
- R11: After reset the block is idle: `busy`, `done` and `mem_we` are 0, `status` reads 0x04000000 and `pass` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Run request, taken only while idle |
| busy | output | 1 | High from accepted start until the run ends |
| done | output | 1 | One-cycle end-of-run pulse |
| mem_addr | output | 32 | Byte address of the current word |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 32 | Write data (current pattern) |
| mem_rdata | input | 32 | Read data, valid one cycle after the address |
| status | output | 32 | Coded result word |
| pass | output | 1 | No failure logged |
| fail_lo_cnt | output | CNT_W | Failures at byte offsets 0..7 of a 16-byte line |
| fail_hi_cnt | output | CNT_W | Failures at byte offsets 8..15 of a 16-byte line |
| fail_map | output | 32 | Failing address windows, indexed by addr[22:18] |

## Verification
On every cycle the assertions check the following: the done pulse length, that start is ignored while busy, that writes happen only during a run and only with one of the two patterns, and that the counters never decrease and rise by at most one per cycle within a run. They also check that the top byte of the status word matches the counters, and that results hold while idle. Only the bench scenarios can show the rest. These are the classification of faults into the low and high counters, which failing address is kept as the maximum, the failing window bits, and that the last word of each pass is compared. They also cover the clearing of logs by a new start and the exact run length. The bench shows these by placing stuck-at bits at chosen words of a memory model that spans a 256 KiB window boundary.

// File: rtl/bist_pkg.sv
package bist_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_CHECK = 2'd2,
        ST_WAIT  = 2'd3
    } bist_state_e;

    // first-pass pattern; the second pass uses its complement
    localparam logic [31:0] PAT_FIRST  = 32'hAAAA_AAAA;
    localparam logic [7:0]  STATUS_TAG = 8'h04;

endpackage

// File: rtl/bist_seq.sv
module bist_seq
    import bist_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR   = 32'h0,
    parameter int          WORDS       = 64,
    parameter int          BURST_WORDS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output logic        busy,
    output logic        done,
    output logic        clr,
    output logic [31:0] mem_addr,
    output logic        mem_we,
    output logic [31:0] mem_wdata,
    output logic        cmp_vld,
    output logic [31:0] cmp_addr,
    output logic [31:0] cmp_exp
);

    localparam int BURSTS  = WORDS / BURST_WORDS;
    localparam int BEAT_W  = (BURST_WORDS > 1) ? $clog2(BURST_WORDS) : 1;
    localparam int BURST_W = (BURSTS > 1) ? $clog2(BURSTS) : 1;

    typedef struct packed {
        bist_state_e        state;
        logic               pass_sel;
        logic [BEAT_W-1:0]  beat;
        logic [BURST_W-1:0] burst;
        logic               cmp_vld;
        logic [31:0]        cmp_addr;
        logic [31:0]        cmp_exp;
        logic               done;
    } seq_t;

    seq_t q, d;

    logic [31:0] pat;
    logic [31:0] word_idx;
    logic [31:0] cur_addr;
    logic        last_beat;
    logic        last_burst;

    always_comb begin
        pat        = q.pass_sel ? ~PAT_FIRST : PAT_FIRST;
        word_idx   = 32'(q.burst) * 32'(BURST_WORDS) + 32'(q.beat);
        cur_addr   = BASE_ADDR + (word_idx << 2);
        last_beat  = (q.beat == BEAT_W'(BURST_WORDS - 1));
        last_burst = (q.burst == BURST_W'(BURSTS - 1));

        d         = q;
        d.done    = 1'b0;
        d.cmp_vld = 1'b0;
        clr       = 1'b0;

        // shared burst/beat stepping for both fill and check
        if (q.state == ST_FILL || q.state == ST_CHECK) begin
            if (last_beat) begin
                d.beat  = '0;
                d.burst = last_burst ? '0 : q.burst + 1'b1;
            end else begin
                d.beat = q.beat + 1'b1;
            end
        end

        case (q.state)
            ST_IDLE: begin
                if (start) begin
                    clr        = 1'b1;
                    d.state    = ST_FILL;
                    d.pass_sel = 1'b0;
                    d.beat     = '0;
                    d.burst    = '0;
                end
            end
            ST_FILL: begin
                if (last_beat && last_burst) d.state = ST_CHECK;
            end
            ST_CHECK: begin
                d.cmp_vld  = 1'b1;
                d.cmp_addr = cur_addr;
                d.cmp_exp  = pat;
                if (last_beat && last_burst) d.state = ST_WAIT;
            end
            ST_WAIT: begin
                // last compare of this pass is consumed at the end of this cycle
                if (q.pass_sel) begin
                    d.state    = ST_IDLE;
                    d.pass_sel = 1'b0;
                    d.done     = 1'b1;
                end else begin
                    d.state    = ST_FILL;
                    d.pass_sel = 1'b1;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state    <= ST_IDLE;
            q.pass_sel <= 1'b0;
            q.beat     <= '0;
            q.burst    <= '0;
            q.cmp_vld  <= 1'b0;
            q.cmp_addr <= '0;
            q.cmp_exp  <= '0;
            q.done     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.state != ST_IDLE);
    assign done      = q.done;
    assign mem_addr  = cur_addr;
    assign mem_we    = (q.state == ST_FILL);
    assign mem_wdata = pat;
    assign cmp_vld   = q.cmp_vld;
    assign cmp_addr  = q.cmp_addr;
    assign cmp_exp   = q.cmp_exp;

endmodule

// File: rtl/bist_log.sv
module bist_log #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             cmp_vld,
    input  logic [31:0]      cmp_addr,
    input  logic [31:0]      cmp_exp,
    input  logic [31:0]      rdata,
    output logic [CNT_W-1:0] lo_cnt,
    output logic [CNT_W-1:0] hi_cnt,
    output logic [31:0]      max_addr,
    output logic [31:0]      fail_map
);

    typedef struct packed {
        logic [CNT_W-1:0] lo;
        logic [CNT_W-1:0] hi;
        logic [31:0]      max;
        logic [31:0]      map;
    } log_t;

    log_t q, d;

    logic        miss;
    logic [31:0] win_hit;

    // one-hot decode of the 256 KiB window index
    for (genvar g = 0; g < 32; g++) begin : g_win
        assign win_hit[g] = (cmp_addr[22:18] == 5'(g));
    end

    always_comb begin
        miss = cmp_vld && (rdata != cmp_exp);
        d    = q;
        if (clr) begin
            d = '0;
        end else if (miss) begin
            if (cmp_addr[3:0] < 4'd8) begin
                if (q.lo != '1) d.lo = q.lo + 1'b1;
            end else begin
                if (q.hi != '1) d.hi = q.hi + 1'b1;
            end
            if (cmp_addr > q.max) d.max = cmp_addr;
            d.map = q.map | win_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign lo_cnt   = q.lo;
    assign hi_cnt   = q.hi;
    assign max_addr = q.max;
    assign fail_map = q.map;

endmodule

// File: rtl/bist_status.sv
module bist_status
    import bist_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic [CNT_W-1:0] lo_cnt,
    input  logic [CNT_W-1:0] hi_cnt,
    input  logic [31:0]      max_addr,
    output logic [31:0]      status,
    output logic             pass_ok
);

    logic lo_any;
    logic hi_any;

    always_comb begin
        lo_any  = (lo_cnt != '0);
        hi_any  = (hi_cnt != '0);
        status  = {STATUS_TAG, 24'h0};
        status  = status | {6'b0, hi_any, lo_any, 24'h0};
        status  = status | (max_addr >> 2);
        pass_ok = !lo_any && !hi_any;
    end

endmodule

// File: rtl/bist_top.sv
module bist_top #(
    parameter logic [31:0] BASE_ADDR    = 32'h0000_0000,
    parameter int          REGION_BYTES = 32'h0180_0000,
    parameter int          BURST_WORDS  = 8,
    parameter int          CNT_W        = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic [31:0]      mem_addr,
    output logic             mem_we,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata,
    output logic [31:0]      status,
    output logic             pass,
    output logic [CNT_W-1:0] fail_lo_cnt,
    output logic [CNT_W-1:0] fail_hi_cnt,
    output logic [31:0]      fail_map
);

    localparam int WORDS = REGION_BYTES / 4;

    logic        clr;
    logic        cmp_vld;
    logic [31:0] cmp_addr;
    logic [31:0] cmp_exp;
    logic [31:0] max_addr;

    bist_seq #(
        .BASE_ADDR  (BASE_ADDR),
        .WORDS      (WORDS),
        .BURST_WORDS(BURST_WORDS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .busy     (busy),
        .done     (done),
        .clr      (clr),
        .mem_addr (mem_addr),
        .mem_we   (mem_we),
        .mem_wdata(mem_wdata),
        .cmp_vld  (cmp_vld),
        .cmp_addr (cmp_addr),
        .cmp_exp  (cmp_exp)
    );

    bist_log #(.CNT_W(CNT_W)) u_log (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .cmp_vld (cmp_vld),
        .cmp_addr(cmp_addr),
        .cmp_exp (cmp_exp),
        .rdata   (mem_rdata),
        .lo_cnt  (fail_lo_cnt),
        .hi_cnt  (fail_hi_cnt),
        .max_addr(max_addr),
        .fail_map(fail_map)
    );

    bist_status #(.CNT_W(CNT_W)) u_stat (
        .lo_cnt  (fail_lo_cnt),
        .hi_cnt  (fail_hi_cnt),
        .max_addr(max_addr),
        .status  (status),
        .pass_ok (pass)
    );

endmodule

// File: rtl/bist_chk.sv
module bist_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             mem_we,
    input logic [31:0]      mem_wdata,
    input logic [31:0]      status,
    input logic             pass,
    input logic [CNT_W-1:0] fail_lo_cnt,
    input logic [CNT_W-1:0] fail_hi_cnt,
    input logic [31:0]      fail_map
);

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(status) && $stable(pass) && $stable(fail_map)));

    a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    a_r1_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done) |=> (busy || done));

    a_r2_write_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    a_r2_r4_write_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata == 32'hAAAA_AAAA || mem_wdata == 32'h5555_5555));

    a_r5_lo_step: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (fail_lo_cnt >= $past(fail_lo_cnt) &&
                  fail_lo_cnt - $past(fail_lo_cnt) <= CNT_W'(1)));

    a_r5_hi_step: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (fail_hi_cnt >= $past(fail_hi_cnt) &&
                  fail_hi_cnt - $past(fail_hi_cnt) <= CNT_W'(1)));

    a_r8_status_tag: assert property (@(posedge clk) disable iff (!rst_n)
        (status[31:26] == 6'b000001) && (status[25] == (fail_hi_cnt != '0)));

    a_r9_pass_counts: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> (fail_lo_cnt == '0 && fail_hi_cnt == '0));

endmodule

bind bist_top bist_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata),
    .status     (status),
    .pass       (pass),
    .fail_lo_cnt(fail_lo_cnt),
    .fail_hi_cnt(fail_hi_cnt),
    .fail_map   (fail_map)
);

// File: tb/sim_bist_top.sv
module sim_bist_top;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] BASE       = 32'h0003_FF80;
    localparam int          REGION     = 256;
    localparam int          W          = REGION / 4;
    localparam int          CNT_W      = 16;
    localparam int          RUN_LAT    = 4 * W + 3;

    typedef struct {
        logic [31:0]      status;
        logic             pass;
        logic [CNT_W-1:0] lo;
        logic [CNT_W-1:0] hi;
        logic [31:0]      map;
        int               lat;
        string            tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             busy, done, mem_we, pass;
    logic [31:0]      mem_addr, mem_wdata, status, fail_map;
    logic [31:0]      mem_rdata = 32'h0;
    logic [CNT_W-1:0] fail_lo_cnt, fail_hi_cnt;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int start_cyc = 0;
    int wr_idx = 0;
    int wr_bad = 0;
    logic prev_done = 1'b0;
    logic [31:0] addr_prev = 32'h0;

    logic [31:0] mem [W];
    logic [31:0] s0 [W];
    logic [31:0] s1 [W];
    exp_t        sb [$];

    bist_top #(
        .BASE_ADDR   (BASE),
        .REGION_BYTES(REGION),
        .BURST_WORDS (8),
        .CNT_W       (CNT_W)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .busy       (busy),
        .done       (done),
        .mem_addr   (mem_addr),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .status     (status),
        .pass       (pass),
        .fail_lo_cnt(fail_lo_cnt),
        .fail_hi_cnt(fail_hi_cnt),
        .fail_map   (fail_map)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int widx(logic [31:0] a);
        return int'(((a - BASE) >> 2) & 32'(W - 1));
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory model: read data for the address of the previous cycle, stuck-at faults on read
    always @(negedge clk) begin
        mem_rdata = (mem[widx(addr_prev)] | s1[widx(addr_prev)]) & ~s0[widx(addr_prev)];
        addr_prev = mem_addr;
        if (rst_n && mem_we) begin
            if (mem_addr !== BASE + 32'((wr_idx % W) * 4)) wr_bad++;
            if (mem_wdata !== ((wr_idx < W) ? 32'hAAAA_AAAA : 32'h5555_5555)) wr_bad++;
            mem[widx(mem_addr)] = mem_wdata;
            wr_idx++;
        end
    end

    // monitor: pops the scoreboard on each done pulse
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done) check("R10", "done width", {31'h0, done}, 32'h0);
            if (done) begin
                if (sb.size() == 0) begin
                    check("R10", "unexpected done", 32'h1, 32'h0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check("R8",  {e.tag, " status"}, status, e.status);
                    check("R9",  {e.tag, " pass"}, {31'h0, pass}, {31'h0, e.pass});
                    check("R5",  {e.tag, " lo count"}, 32'(fail_lo_cnt), 32'(e.lo));
                    check("R5",  {e.tag, " hi count"}, 32'(fail_hi_cnt), 32'(e.hi));
                    check("R7",  {e.tag, " map"}, fail_map, e.map);
                    check("R10", {e.tag, " latency"}, 32'(cyc - start_cyc), 32'(e.lat));
                end
            end
            prev_done = done;
        end
    end

    // reference model of the whole run (R4, R5, R6, R7, R8, R9)
    task automatic push_expected(string tag);
        exp_t e;
        logic [31:0] mx = 32'h0;
        e.lo = '0; e.hi = '0; e.map = 32'h0;
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < W; i++) begin
                logic [31:0] pt;
                logic [31:0] a;
                logic [31:0] v;
                pt = (p == 0) ? 32'hAAAA_AAAA : 32'h5555_5555;
                a  = BASE + 32'(i * 4);
                v  = (pt | s1[i]) & ~s0[i];
                if (v != pt) begin
                    if (a[3:0] < 4'd8) e.lo++;
                    else               e.hi++;
                    if (a > mx) mx = a;
                    e.map[a[22:18]] = 1'b1;
                end
            end
        end
        e.status = 32'h0400_0000 | ((e.hi != 0) ? 32'h0200_0000 : 32'h0)
                 | ((e.lo != 0) ? 32'h0100_0000 : 32'h0) | (mx >> 2);
        e.pass = (e.lo == 0) && (e.hi == 0);
        e.lat  = RUN_LAT;
        e.tag  = tag;
        sb.push_back(e);
    endtask

    task automatic clear_faults();
        for (int i = 0; i < W; i++) begin
            s0[i] = 32'h0;
            s1[i] = 32'h0;
        end
    endtask

    task automatic run(string tag, bit extra_start);
        logic [31:0] held;
        int bad0;
        bad0 = wr_bad;
        push_expected(tag);
        @(negedge clk);
        wr_idx    = 0;
        start_cyc = cyc;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (extra_start) begin
            repeat (20) @(negedge clk);
            start = 1'b1;        // R1: ignored while busy
            @(negedge clk);
            start = 1'b0;
        end
        while (sb.size() != 0) @(negedge clk);
        check("R2", {tag, " write order/data"}, 32'(wr_bad - bad0), 32'h0);
        check("R2", {tag, " write count"}, 32'(wr_idx), 32'(2 * W));
        held = status;
        repeat (10) @(negedge clk);
        check("R10", {tag, " status held"}, status, held);
    endtask

    initial begin
        for (int i = 0; i < W; i++) mem[i] = 32'h0;
        clear_faults();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", "busy", {31'h0, busy}, 32'h0);
        check("R11", "done", {31'h0, done}, 32'h0);
        check("R11", "we", {31'h0, mem_we}, 32'h0);
        check("R11", "status", status, 32'h0400_0000);
        check("R11", "pass", {31'h0, pass}, 32'h1);

        clear_faults();
        run("clean", 1'b0);

        // R5 low nibble, R4 only first pattern trips
        clear_faults();
        s0[4] = 32'h0000_0002;
        run("lo_fault", 1'b0);

        // R1 logs cleared by a new start
        clear_faults();
        run("cleared", 1'b0);

        // R3 last word, R5 high nibble, R4 second pattern, R7 two windows, R1 extra start
        clear_faults();
        s1[63] = 32'h0000_0001;
        s1[2]  = 32'h0000_0002;
        run("hi_last", 1'b1);

        // R6 maximum kept when a lower address fails later
        clear_faults();
        s0[40] = 32'hFFFF_FFFF;
        s0[10] = 32'hFFFF_FFFF;
        s1[13] = 32'h8000_0000;
        run("max_order", 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule